// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers interrupt events for a small 8-bit processor core and turns them into two request lines, one high priority and one low priority, plus a wake-up line for low-power states. There are five sources. Three are external pins, each with its own choice of trigger edge. One is a timer overflow strobe, which can follow either an 8-bit or a 16-bit wrap. One is a change detector that watches four port bits. The pins and the port bits pass through a two-flop synchronizer before any edge or change detection. The change detector compares the synchronized port value against a registered copy of its previous value.

Each source has a sticky flag, an enable and, except for external source 0, a priority bit. All of these sit in four byte-wide registers on a simple register bus with a write strobe and a combinational read. Software clears a flag by writing the flag register. An event that arrives in the same cycle as that write wins over it, so no event is lost. A global enable gates both request lines. Wake-up does not depend on it: wake-up follows the external flags and their enables only.

Register map, by `reg_addr`:
- 0, flags: bit0 ext0, bit1 ext1, bit2 ext2, bit3 timer, bit4 port change.
- 1, enables: bits 4:0 in the same order as the flags, and bit7 is the global enable.
- 2, priority: bit6 ext1, bit7 ext2, bit3 timer, bit4 port change.
- 3, config: bits 2:0 select the edge for ext0..ext2, and bit3 selects 16-bit timer mode.

Unlisted bits read 0.

Top module: `prio_irq_ctrl`

## Requirements
- R1: With config bit k = 1, a rising edge on `ext_pin[k]` sets flag bit k. With config bit k = 0, a falling edge sets it. The edge of the other polarity leaves the flag clear. The flag is readable no later than the third clock edge after the pin changes.
- R2: A set flag stays set until software writes the flag register (address 0). A write replaces the flags with `reg_wdata[4:0]`, so writing 0 clears them.
- R3: An enable bit of 0 suppresses that source's contribution to `irq_hi`, `irq_lo` and `wake`. It does not stop the source's flag from being set.
- R4: External source 0 always drives `irq_hi`. For every other source, a priority bit of 1 routes it to `irq_hi` and a 0 routes it to `irq_lo`. The priority bits are ext1 = bit6, ext2 = bit7, timer = bit3 and port = bit4 of address 2.
- R5: `irq_hi` and `irq_lo` are 0 while the global enable (address 1 bit7) is 0. `wake` is 1 whenever an external flag and its enable are both 1, whatever the global enable.
- R6: With config bit3 = 0, `tmr_wrap8` sets the timer flag (bit3) and `tmr_wrap16` is ignored. With config bit3 = 1 the roles are swapped.
- R7: Any change on `port_in[3:0]`, in either direction and on any bit, sets the port-change flag (bit4).
- R8: If a flag-register write and a source event fall in the same cycle, that source's flag ends set.
- R9: After reset, the flag, enable and config registers read 0x00 and the priority register reads 0xD8, so every priority bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 3 | External interrupt pins, asynchronous |
| port_in | input | 4 | Watched port bits, asynchronous |
| tmr_wrap8 | input | 1 | One-cycle strobe on an 8-bit timer wrap |
| tmr_wrap16 | input | 1 | One-cycle strobe on a 16-bit timer wrap |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_hi | output | 1 | High-priority request |
| irq_lo | output | 1 | Low-priority request |
| wake | output | 1 | Wake-up request |

## Verification
The two functions that can land in the same cycle are a software write that clears the flags and a new source event. The bench first sets a flag, then in one cycle writes 0 to the flag register while pulsing the selected timer wrap strobe. A read-back of exactly the timer flag shows that the write cleared the old flag and that the event survived it. A plain clear afterwards confirms that the flag does fall once no event competes with the write.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int N_EXT  = 3;
    localparam int N_SRC  = 5;
    localparam int S_TMR  = 3;
    localparam int S_CHG  = 4;
    localparam int GIE_B  = 7;
    localparam int MODE_B = 3;
    localparam int PX1_B  = 6;
    localparam int PX2_B  = 7;
    localparam int PTM_B  = 3;
    localparam int PCH_B  = 4;

    typedef enum logic [1:0] {
        A_FLAG = 2'd0,
        A_EN   = 2'd1,
        A_PRIO = 2'd2,
        A_CFG  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/intc_edge.sv
module intc_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] rise_sel,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    for (genvar g = 0; g < W; g++) begin : g_pin
        assign hit[g] = rise_sel[g] ? (lvl[g] & ~prev_q[g])
                                    : (~lvl[g] & prev_q[g]);
    end
endmodule

// File: rtl/intc_chg.sv
module intc_chg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic         changed
);
    logic [W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= lvl;
    end

    assign changed = |(lvl ^ last_q);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import intc_pkg::*;
#(
    parameter int PORT_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EXT-1:0]  ext_pin,
    input  logic [PORT_W-1:0] port_in,
    input  logic              tmr_wrap8,
    input  logic              tmr_wrap16,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_hi,
    output logic              irq_lo,
    output logic              wake
);
    logic [N_EXT-1:0]  ext_s;
    logic [PORT_W-1:0] port_s;
    logic [N_EXT-1:0]  ext_hit;
    logic              chg_hit;
    logic              tmr_hit;
    logic [N_SRC-1:0]  ev;

    logic [N_SRC-1:0]  flag_q;
    logic [N_SRC-1:0]  en_q;
    logic              gie_q;
    logic [N_SRC-1:0]  prio_q;
    logic [N_EXT-1:0]  edge_q;
    logic              mode16_q;

    logic [N_SRC-1:0]  pend;
    logic              wr_flag, wr_en, wr_prio, wr_cfg;
    logic              unused_wbits;
    reg_sel_e          sel;

    intc_sync #(.W(N_EXT), .STAGES(SYNC_STAGES)) u_sync_ext (
        .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(ext_s)
    );

    intc_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync_port (
        .clk(clk), .rst_n(rst_n), .d(port_in), .q(port_s)
    );

    intc_edge #(.W(N_EXT)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(ext_s), .rise_sel(edge_q), .hit(ext_hit)
    );

    intc_chg #(.W(PORT_W)) u_chg (
        .clk(clk), .rst_n(rst_n), .lvl(port_s), .changed(chg_hit)
    );

    assign tmr_hit = mode16_q ? tmr_wrap16 : tmr_wrap8;
    assign ev      = {chg_hit, tmr_hit, ext_hit};

    assign sel     = reg_sel_e'(reg_addr[1:0]);
    assign wr_flag = reg_we && (sel == A_FLAG);
    assign wr_en   = reg_we && (sel == A_EN);
    assign wr_prio = reg_we && (sel == A_PRIO);
    assign wr_cfg  = reg_we && (sel == A_CFG);

    assign unused_wbits = ^{reg_wdata[DATA_W-1:0], reg_addr};

    // Flags: an event in the cycle of a clearing write still sets the flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (wr_flag ? reg_wdata[N_SRC-1:0] : flag_q) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            gie_q    <= 1'b0;
            prio_q   <= '1;
            edge_q   <= '0;
            mode16_q <= 1'b0;
        end else begin
            if (wr_en) begin
                en_q  <= reg_wdata[N_SRC-1:0];
                gie_q <= reg_wdata[GIE_B];
            end
            if (wr_prio) begin
                prio_q <= {reg_wdata[PCH_B], reg_wdata[PTM_B],
                           reg_wdata[PX2_B], reg_wdata[PX1_B], 1'b1};
            end
            if (wr_cfg) begin
                edge_q   <= reg_wdata[N_EXT-1:0];
                mode16_q <= reg_wdata[MODE_B];
            end
        end
    end

    // prio_q[0] is held at 1: external source 0 is always high priority.
    assign pend   = flag_q & en_q;
    assign irq_hi = gie_q & |(pend & prio_q);
    assign irq_lo = gie_q & |(pend & ~prio_q);
    assign wake   = |pend[N_EXT-1:0];

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            A_FLAG: reg_rdata[N_SRC-1:0] = flag_q;
            A_EN: begin
                reg_rdata[N_SRC-1:0] = en_q;
                reg_rdata[GIE_B]     = gie_q;
            end
            A_PRIO: begin
                reg_rdata[PX1_B] = prio_q[1];
                reg_rdata[PX2_B] = prio_q[2];
                reg_rdata[PTM_B] = prio_q[S_TMR];
                reg_rdata[PCH_B] = prio_q[S_CHG];
            end
            A_CFG: begin
                reg_rdata[N_EXT-1:0] = edge_q;
                reg_rdata[MODE_B]    = mode16_q;
            end
        endcase
    end
endmodule

// File: rtl/intc_chk.sv
module intc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] flag,
    input logic [4:0] en,
    input logic       gie,
    input logic       mode16,
    input logic       reg_we,
    input logic [1:0] reg_addr,
    input logic       tmr_wrap8,
    input logic       tmr_wrap16,
    input logic       irq_hi,
    input logic       irq_lo,
    input logic       wake
);
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == 2'd0) |=> ((flag & $past(flag)) == $past(flag)));

    p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag & en) == 5'd0) |-> !(irq_hi || irq_lo || wake));

    p_ext0_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gie && flag[0] && en[0]) |-> irq_hi);

    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> (!irq_hi && !irq_lo));

    p_wake_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (en[2:0] != 3'd0));

    p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd0 && (mode16 ? tmr_wrap16 : tmr_wrap8)) |=> flag[3]);
endmodule

bind prio_irq_ctrl intc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .flag(flag_q), .en(en_q), .gie(gie_q),
    .mode16(mode16_q), .reg_we(reg_we), .reg_addr(reg_addr),
    .tmr_wrap8(tmr_wrap8), .tmr_wrap16(tmr_wrap16),
    .irq_hi(irq_hi), .irq_lo(irq_lo), .wake(wake)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ext_pin = '0;
    logic [3:0] port_in = '0;
    logic       tmr_wrap8 = 1'b0;
    logic       tmr_wrap16 = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_hi, irq_lo, wake;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        bit         is_out;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t q[$];

    always #4 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_in(port_in),
        .tmr_wrap8(tmr_wrap8), .tmr_wrap16(tmr_wrap16), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_hi(irq_hi), .irq_lo(irq_lo), .wake(wake)
    );

    // Monitor: compares one queued expectation per falling edge.
    always @(negedge clk) begin
        item_t it;
        logic [7:0] act;
        if (q.size() > 0) begin
            it  = q.pop_front();
            act = it.is_out ? {5'b0, wake, irq_lo, irq_hi} : reg_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk);
        reg_we <= 1'b1; reg_addr <= a; reg_wdata <= d;
        @(posedge clk);
        reg_we <= 1'b0;
    endtask

    task automatic chk_reg(input logic [1:0] a, input logic [7:0] e, input string t);
        @(posedge clk);
        reg_addr <= a;
        q.push_back('{is_out: 1'b0, exp: e, tag: t});
        @(posedge clk);
    endtask

    // expected {wake, irq_lo, irq_hi}
    task automatic chk_out(input logic [2:0] e, input string t);
        @(posedge clk);
        q.push_back('{is_out: 1'b1, exp: {5'b0, e}, tag: t});
        @(posedge clk);
    endtask

    task automatic pulse8();
        @(posedge clk); tmr_wrap8 <= 1'b1;
        @(posedge clk); tmr_wrap8 <= 1'b0;
    endtask

    task automatic pulse16();
        @(posedge clk); tmr_wrap16 <= 1'b1;
        @(posedge clk); tmr_wrap16 <= 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n <= 1'b1;
        tick(2);

        // R9 reset values
        chk_reg(2'd0, 8'h00, "R9 flags");
        chk_reg(2'd1, 8'h00, "R9 enables");
        chk_reg(2'd2, 8'hD8, "R9 priority");
        chk_reg(2'd3, 8'h00, "R9 config");
        chk_out(3'b000, "R9 outputs");

        // R1 falling edge selected by default on ext0
        @(posedge clk); ext_pin[0] <= 1'b1; tick(4);
        chk_reg(2'd0, 8'h00, "R1 rising ignored");
        @(posedge clk); ext_pin[0] <= 1'b0; tick(4);
        chk_reg(2'd0, 8'h01, "R1 falling sets");
        wr(2'd0, 8'h00);
        // R1 rising edge on ext1
        wr(2'd3, 8'h02);
        @(posedge clk); ext_pin[1] <= 1'b1; tick(4);
        chk_reg(2'd0, 8'h02, "R1 rising sets");
        @(posedge clk); ext_pin[1] <= 1'b0; tick(4);
        chk_reg(2'd0, 8'h02, "R1 falling ignored");

        // R3 flag present but masked
        wr(2'd1, 8'h80);
        chk_out(3'b000, "R3 masked");
        chk_reg(2'd0, 8'h02, "R3 flag kept");

        // R4 routing
        wr(2'd1, 8'h82);
        chk_out(3'b101, "R4 ext1 high");
        wr(2'd2, 8'h00);
        chk_out(3'b110, "R4 ext1 low");
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h81);
        chk_out(3'b101, "R4 ext0 always high");

        // R5 global enable
        wr(2'd1, 8'h01);
        chk_out(3'b100, "R5 wake without gie");
        wr(2'd1, 8'h00);
        chk_out(3'b000, "R3 enable off");

        // R2 sticky and clear
        tick(5);
        chk_reg(2'd0, 8'h01, "R2 sticky");
        wr(2'd0, 8'h00);
        chk_reg(2'd0, 8'h00, "R2 cleared");

        // R6 timer mode
        pulse16(); tick(1);
        chk_reg(2'd0, 8'h00, "R6 wrap16 ignored in 8-bit");
        pulse8(); tick(1);
        chk_reg(2'd0, 8'h08, "R6 wrap8 sets");
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h08);
        pulse8(); tick(1);
        chk_reg(2'd0, 8'h00, "R6 wrap8 ignored in 16-bit");
        pulse16(); tick(1);
        chk_reg(2'd0, 8'h08, "R6 wrap16 sets");
        wr(2'd1, 8'h88);
        chk_out(3'b010, "R4 timer low");
        wr(2'd2, 8'h08);
        chk_out(3'b001, "R4 timer high");
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);

        // R7 port change
        @(posedge clk); port_in <= 4'b0100; tick(4);
        chk_reg(2'd0, 8'h10, "R7 change up");
        wr(2'd0, 8'h00);
        @(posedge clk); port_in <= 4'b0000; tick(4);
        chk_reg(2'd0, 8'h10, "R7 change down");
        wr(2'd0, 8'h00);
        @(posedge clk); port_in <= 4'b1001; tick(4);
        chk_reg(2'd0, 8'h10, "R7 two bits");
        wr(2'd0, 8'h00);
        tick(4);
        chk_reg(2'd0, 8'h00, "R7 steady no flag");

        // R8 clear write colliding with a timer event (16-bit mode)
        wr(2'd0, 8'h01);
        @(posedge clk);
        reg_we <= 1'b1; reg_addr <= 2'd0; reg_wdata <= 8'h00; tmr_wrap16 <= 1'b1;
        @(posedge clk);
        reg_we <= 1'b0; tmr_wrap16 <= 1'b0;
        chk_reg(2'd0, 8'h08, "R8 event wins");
        wr(2'd0, 8'h00);
        chk_reg(2'd0, 8'h00, "R8 later clear");

        tick(3);
        wait (q.size() == 0);
        tick(1);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule